// File: doc/BRIEF.md
# Timer Clock Prescaler and Selector

This block turns one system clock into single-cycle count-enable strobes for six timer slices: timer 0, timer 1, and the low and high bytes of timers 2 and 3. A shared divider produces one prescaled tick. A two-bit field in an 8-bit control register sets its rate: the system clock divided by 12, 4 or 48, or a synchronized external clock divided by 8. Each timer has a select bit. For timers 0 and 1 this bit chooses between the shared tick and a strobe on every cycle. For timers 2 and 3 it chooses between every cycle and that timer's own alternate tick.

The alternate tick of timer 2 or 3 comes from its own external-select input. A 0 gives a fixed divide-by-12 of the system clock. A 1 gives the synchronized external clock divided by 8. No enable is a derived clock, so the whole block runs in one clock domain. The control register is loaded through a single write strobe and resets to zero, which means divide-by-12 with every timer on the prescaled path.

Top module: `tmr_tick_gen`

## Requirements
- R1: With the prescale field (control bits 1:0) at 00, 01 or 10, the shared tick pulses for one cycle every 12, 4 or 48 system cycles. Timers 0 and 1 with a select bit of 0 follow that tick.
- R2: With the prescale field at 11, the shared tick pulses once for every eighth rising edge of the external clock, after a two-flop synchronizer. With no external edges it never pulses.
- R3: A select bit of 1 (bit 2 for timer 0, bit 3 for timer 1) makes that timer's enable high on every system cycle.
- R4: While a timer's counter-mode input is 1, the enable of timer 0 or timer 1 stays low whatever its select bit is.
- R5: With timer 2 or 3 not split, its high-byte enable equals its low-byte enable. The high-byte select bit (bit 5 for timer 2, bit 7 for timer 3) is then ignored. In split mode the high-byte enable is chosen by the high-byte select bit.
- R6: With a low-byte select bit (bit 4 for timer 2, bit 6 for timer 3) at 0, that timer's low-byte enable follows its alternate tick. An external-select input of 0 gives a fixed divide-by-12, independent of the prescale field. An input of 1 gives the external clock divided by 8.
- R7: Every register write restarts the shared divider, so the first shared tick comes exactly one full period (N cycles) after the write edge.
- R8: After reset the control register is zero, so timer 0 pulses every 12 cycles and every enable is low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| ext_clk | input | 1 | External clock, asynchronous |
| t0_cnt_mode | input | 1 | Timer 0 counter mode (1 = counts pin events) |
| t1_cnt_mode | input | 1 | Timer 1 counter mode |
| t2_split | input | 1 | Timer 2 split 8-bit mode |
| t3_split | input | 1 | Timer 3 split 8-bit mode |
| t2_ext_sel | input | 1 | Timer 2 alternate tick: 0 = sysclk/12, 1 = external/8 |
| t3_ext_sel | input | 1 | Timer 3 alternate tick select |
| t0_en | output | 1 | Timer 0 count enable |
| t1_en | output | 1 | Timer 1 count enable |
| t2_lo_en | output | 1 | Timer 2 low-byte count enable |
| t2_hi_en | output | 1 | Timer 2 high-byte count enable |
| t3_lo_en | output | 1 | Timer 3 low-byte count enable |
| t3_hi_en | output | 1 | Timer 3 high-byte count enable |

## Verification
The bench sweeps all four prescale codes and measures both the delay from the write to the first strobe and the spacing between later strobes. The first figure separates a divider that restarts on a write from one that runs freely. The second separates the three system ratios from one another. A free-running external square wave checks the divide-by-8 path, and stopping that wave shows that no tick arises without edges. Select, counter-mode, split and external-select combinations are then tried so that every-cycle strobes, suppressed strobes, copied high-byte strobes and alternate ticks each give a distinct pulse count or spacing.

// File: rtl/tck_pkg.sv
package tck_pkg;
  typedef enum logic [1:0] {
    PS_DIV12 = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV48 = 2'b10,
    PS_EXT8  = 2'b11
  } ps_sel_e;

  localparam int unsigned NUM_TMR  = 6;
  localparam int unsigned NUM_WIDE = 2;
endpackage

// File: rtl/tck_sysdiv.sv
module tck_sysdiv #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] ratio,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  always_comb begin
    hit = (cnt_q == ratio - 1'b1);
    if (restart)  cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = hit & ~restart;

  p_restart_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  p_wrap_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/tck_extdiv.sv
module tck_extdiv #(
  parameter int unsigned EXT_DIV = 8,
  localparam int unsigned EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ext_in,
  output logic tick
);
  logic          s1_q, s2_q, s3_q;
  logic          rise, hit;
  logic [EW-1:0] ec_q, ec_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    rise = s2_q & ~s3_q;
    hit  = rise && (ec_q == EW'(EXT_DIV - 1));
    if (restart)    ec_d = '0;
    else if (hit)   ec_d = '0;
    else if (rise)  ec_d = ec_q + 1'b1;
    else            ec_d = ec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ec_q <= '0;
    else        ec_q <= ec_d;
  end

  assign tick = hit & ~restart;

  p_tick_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (s2_q && !s3_q));
  p_hold_no_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !restart) |=> $stable(ec_q));
endmodule

// File: rtl/tck_wide_route.sv
module tck_wide_route (
  input  logic split,
  input  logic ext_sel,
  input  logic lo_sel,
  input  logic hi_sel,
  input  logic alt_sys_tick,
  input  logic alt_ext_tick,
  output logic lo_en,
  output logic hi_en
);
  logic alt_tick, hi_own;

  always_comb begin
    alt_tick = ext_sel ? alt_ext_tick : alt_sys_tick;
    lo_en    = lo_sel ? 1'b1 : alt_tick;
    hi_own   = hi_sel ? 1'b1 : alt_tick;
    hi_en    = split ? hi_own : lo_en;
  end

  always_comb begin
    if (!split) p_hi_follows_lo_r5: assert (hi_en == lo_en);
  end
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tck_pkg::*;
#(
  parameter int unsigned DIV_A   = 12,
  parameter int unsigned DIV_B   = 4,
  parameter int unsigned DIV_C   = 48,
  parameter int unsigned EXT_DIV = 8,
  parameter int unsigned ALT_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       ext_clk,
  input  logic       t0_cnt_mode,
  input  logic       t1_cnt_mode,
  input  logic       t2_split,
  input  logic       t3_split,
  input  logic       t2_ext_sel,
  input  logic       t3_ext_sel,
  output logic       t0_en,
  output logic       t1_en,
  output logic       t2_lo_en,
  output logic       t2_hi_en,
  output logic       t3_lo_en,
  output logic       t3_hi_en
);
  localparam int unsigned MAXD1 = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned MAXD2 = (MAXD1 > DIV_C) ? MAXD1 : DIV_C;
  localparam int unsigned MAXD  = (MAXD2 > ALT_DIV) ? MAXD2 : ALT_DIV;
  localparam int unsigned CW    = $clog2(MAXD + 1);

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  // control register
  logic [7:0] cfg_q, cfg_d;
  always_comb cfg_d = cfg_we ? cfg_wdata : cfg_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  ps_sel_e       ps;
  logic [CW-1:0] ratio;
  logic          sys_tick, ext_tick, alt12_tick, shared_tick;

  always_comb begin
    ps = ps_sel_e'(cfg_q[1:0]);
    unique case (ps)
      PS_DIV12: ratio = CW'(DIV_A);
      PS_DIV4:  ratio = CW'(DIV_B);
      PS_DIV48: ratio = CW'(DIV_C);
      default:  ratio = CW'(DIV_A);
    endcase
  end

  tck_sysdiv #(.CW(CW)) i_shared_div (
    .clk(clk), .rst_n(srst_n), .restart(cfg_we), .ratio(ratio), .tick(sys_tick)
  );

  tck_sysdiv #(.CW(CW)) i_alt_div (
    .clk(clk), .rst_n(srst_n), .restart(1'b0), .ratio(CW'(ALT_DIV)), .tick(alt12_tick)
  );

  tck_extdiv #(.EXT_DIV(EXT_DIV)) i_ext_div (
    .clk(clk), .rst_n(srst_n), .restart(cfg_we), .ext_in(ext_clk), .tick(ext_tick)
  );

  assign shared_tick = (ps == PS_EXT8) ? ext_tick : sys_tick;

  // timers 0 and 1
  logic [1:0] nar_en, nar_sel, nar_cmode;
  assign nar_sel   = cfg_q[3:2];
  assign nar_cmode = {t1_cnt_mode, t0_cnt_mode};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_nar
      always_comb begin
        if (nar_cmode[g])     nar_en[g] = 1'b0;
        else if (nar_sel[g])  nar_en[g] = 1'b1;
        else                  nar_en[g] = shared_tick;
      end
    end
  endgenerate

  assign t0_en = nar_en[0];
  assign t1_en = nar_en[1];

  // timers 2 and 3
  logic [NUM_WIDE-1:0] w_split, w_ext, w_lo_sel, w_hi_sel, w_lo_en, w_hi_en;
  assign w_split  = {t3_split, t2_split};
  assign w_ext    = {t3_ext_sel, t2_ext_sel};
  assign w_lo_sel = {cfg_q[6], cfg_q[4]};
  assign w_hi_sel = {cfg_q[7], cfg_q[5]};

  generate
    for (genvar w = 0; w < NUM_WIDE; w++) begin : g_wide
      tck_wide_route i_route (
        .split(w_split[w]), .ext_sel(w_ext[w]),
        .lo_sel(w_lo_sel[w]), .hi_sel(w_hi_sel[w]),
        .alt_sys_tick(alt12_tick), .alt_ext_tick(ext_tick),
        .lo_en(w_lo_en[w]), .hi_en(w_hi_en[w])
      );
    end
  endgenerate

  assign t2_lo_en = w_lo_en[0];
  assign t2_hi_en = w_hi_en[0];
  assign t3_lo_en = w_lo_en[1];
  assign t3_hi_en = w_hi_en[1];

  p_cnt_mode_quiet_r4: assert property (@(posedge clk) disable iff (!srst_n)
    t0_cnt_mode |-> !t0_en);
  p_bypass_every_cycle_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(cfg_q[3]) && cfg_q[3] && !t1_cnt_mode) |-> t1_en);
  p_single_cycle_tick_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (sys_tick && ratio > CW'(1)) |=> !sys_tick);
  p_reset_quiet_r8: assert property (@(posedge clk)
    !srst_n |-> (cfg_q == 8'h00));
endmodule

// File: tb/test_tmr_tick_gen.sv
module test_tmr_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       ext_clk = 1'b0;
  logic       t0_cnt_mode = 1'b0, t1_cnt_mode = 1'b0;
  logic       t2_split = 1'b0, t3_split = 1'b0;
  logic       t2_ext_sel = 1'b0, t3_ext_sel = 1'b0;
  logic       t0_en, t1_en, t2_lo_en, t2_hi_en, t3_lo_en, t3_hi_en;
  logic       ext_run = 1'b0;
  logic [5:0] en_vec;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign en_vec = {t3_hi_en, t3_lo_en, t2_hi_en, t2_lo_en, t1_en, t0_en};

  tmr_tick_gen i_tmr_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_clk(ext_clk), .t0_cnt_mode(t0_cnt_mode), .t1_cnt_mode(t1_cnt_mode),
    .t2_split(t2_split), .t3_split(t3_split),
    .t2_ext_sel(t2_ext_sel), .t3_ext_sel(t3_ext_sel),
    .t0_en(t0_en), .t1_en(t1_en), .t2_lo_en(t2_lo_en), .t2_hi_en(t2_hi_en),
    .t3_lo_en(t3_lo_en), .t3_hi_en(t3_hi_en)
  );

  // external clock: period of 6 system cycles while running
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph = ph + 1;
        if (ph == 3) begin
          ext_clk = ~ext_clk;
          ph = 0;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  // negedges until the selected enable is seen high (cap 1000)
  task automatic to_pulse(input int idx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!en_vec[idx] && n < 1000);
  endtask

  task automatic count_pulses(input int idx, input int ncyc, output int c);
    c = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (en_vec[idx]) c++;
    end
  endtask

  task automatic interval(input int idx, output int n);
    int dummy;
    to_pulse(idx, dummy);
    to_pulse(idx, n);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, c;
    int ratios[3];
    ratios[0] = 12; ratios[1] = 4; ratios[2] = 48;

    // R8: quiet during reset, default divide-by-12 after
    repeat (4) @(negedge clk);
    check("R8 reset enables", int'(en_vec), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    interval(0, n);
    check("R8 default t0 interval", n, 12);

    // R1 / R7: every system prescale code, first tick and spacing
    for (int p = 0; p < 3; p++) begin
      wr(8'(p));
      to_pulse(0, n);
      check("R7 first tick after write", n, ratios[p]);
      to_pulse(0, n);
      check("R1 tick spacing", n, ratios[p]);
      check("R1 t1 same tick", int'(t1_en), 1);
    end

    // R2: external clock divided by 8
    ext_run = 1'b1;
    wr(8'h03);
    interval(0, n);
    check("R2 external tick spacing", n, 48);
    interval(1, n);
    check("R2 external tick t1", n, 48);
    ext_run = 1'b0;
    repeat (6) @(negedge clk);
    count_pulses(0, 200, c);
    check("R2 no edges no tick", c, 0);

    // R3: bypass select bits
    wr(8'h0C);
    count_pulses(0, 20, c);
    check("R3 t0 every cycle", c, 20);
    count_pulses(1, 20, c);
    check("R3 t1 every cycle", c, 20);

    // R4: counter mode suppresses timer 0 enable
    t0_cnt_mode = 1'b1;
    count_pulses(0, 30, c);
    check("R4 t0 counter mode sel=1", c, 0);
    wr(8'h09);
    count_pulses(0, 30, c);
    check("R4 t0 counter mode sel=0", c, 0);
    count_pulses(1, 30, c);
    check("R4 t1 unaffected", c, 30);
    t0_cnt_mode = 1'b0;

    // R5: timer 2 split behaviour
    wr(8'h10);
    count_pulses(2, 20, c);
    check("R5 t2 lo every cycle", c, 20);
    count_pulses(3, 20, c);
    check("R5 t2 hi copies lo", c, 20);
    wr(8'h20);
    interval(3, n);
    check("R5 hi sel ignored unsplit", n, 12);
    t2_split = 1'b1;
    count_pulses(3, 20, c);
    check("R5 split hi every cycle", c, 20);
    interval(2, n);
    check("R5 split lo alternate", n, 12);
    t2_split = 1'b0;

    // R6: alternate tick sources for timer 3
    ext_run = 1'b1;
    t3_ext_sel = 1'b1;
    wr(8'h01);
    interval(4, n);
    check("R6 t3 external alt", n, 48);
    t3_ext_sel = 1'b0;
    interval(4, n);
    check("R6 t3 fixed div12 alt", n, 12);
    t3_split = 1'b1;
    wr(8'h81);
    count_pulses(5, 10, c);
    check("R6 t3 hi split every cycle", c, 10);
    ext_run = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule